// File: doc/BRIEF.md
# Washing Machine Cycle Controller

This block sequences a domestic washer through a fixed programme: fill and agitate for the wash, pump out, fill with cold water and agitate for the rinse, pump out again, then spin. A user start button launches the programme and a hot-water select picks the wash temperature. A tank-full level input gates the fill valves and the agitator. A done pulse from an external cycle timer ends each agitate and spin phase. The controller drives the hot and cold valves, the agitator, the drain pump, the spin motor and a strobe that restarts the timer.

All next-phase and actuator decisions come from a 256-word by 8-bit lookup table. The table is addressed by the current phase code together with the five inputs, and its contents are computed at elaboration. A three-bit phase register closes the loop around the table. The timer-start bit from the table passes through one more flip-flop, so the timer sees it only from the next clock edge. Pressing the off button freezes the machine in its current phase with every actuator closed. The freeze holds until start is pressed again.

Top module: `wm_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `phase` to Idle (0) and `timer_start` to 0.
- R2: In Idle, with no freeze in force, the phase moves to Wash (1) at the next edge only when `start_btn` is high. Otherwise it stays in Idle, and all actuators are off in Idle.
- R3: In Wash, while `tank_full` is low, `hot_valve` is on if `hot_sel` is high and `cold_valve` is on otherwise. In Rinse (3), while `tank_full` is low, only `cold_valve` is on. In both phases, when `tank_full` is high, the valves are closed and `agitator` is on.
- R4: The phase advances as follows: Wash to Drain (2) when `timer_done` and `tank_full` are both high; Drain to Rinse (3) when `tank_full` is low; Rinse to Flush (4) when `timer_done` and `tank_full` are both high; Flush to Spin (5) when `tank_full` is low; Spin to Idle when `timer_done` is high. In every other case the phase holds.
- R5: `drain_pump` is on in Drain and in Flush, and `spin_motor` is on in Spin. Neither is on in any other phase.
- R6: `timer_start` is high for exactly the first cycle after a transition into Wash, Rinse or Spin, and low in every other cycle.
- R7: While `off_btn` is high the phase holds and every actuator and `timer_start` is off. After `off_btn` falls, the freeze continues, ignoring `timer_done` and `tank_full`, until a cycle with `start_btn` high. In that cycle the phase's normal behaviour applies.
- R8: The phase codes are Idle=0, Wash=1, Drain=2, Rinse=3, Flush=4, Spin=5, and `phase` never carries 6 or 7.
- R9: At most one of {a fill valve, `agitator`, `drain_pump`, `spin_motor`} is on at a time, and `hot_valve` and `cold_valve` are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_btn | input | 1 | User start / resume button |
| off_btn | input | 1 | User off button, freezes the programme |
| hot_sel | input | 1 | High selects hot water for the wash fill |
| timer_done | input | 1 | End-of-phase pulse from the external timer |
| tank_full | input | 1 | Tank level at full |
| hot_valve | output | 1 | Hot fill valve |
| cold_valve | output | 1 | Cold fill valve |
| agitator | output | 1 | Agitator motor |
| drain_pump | output | 1 | Drain pump |
| spin_motor | output | 1 | Spin motor |
| timer_start | output | 1 | Registered timer restart strobe |
| phase | output | 3 | Current phase code |

## Verification
The interesting collision is between a freeze and a phase exit: `off_btn` can be high in the same cycle that `timer_done`/`tank_full` would advance the phase or that `start_btn` would leave Idle. The bench provokes this by walking the machine to each of the six phases and applying all 32 input combinations there. It judges the freeze by checking that the phase holds, the actuators are dark and no timer strobe follows. A second collision is the resume cycle itself: start arrives while the stored freeze is still set, together with a timer done. The bench checks that the phase exits in that very cycle.

// File: rtl/wm_pkg.sv
package wm_pkg;

  localparam int PH_W   = 3;
  localparam int IN_W   = 5;
  localparam int ADDR_W = PH_W + IN_W;
  localparam int DATA_W = PH_W + 5;

  typedef enum logic [PH_W-1:0] {
    PH_IDLE  = 3'd0,
    PH_WASH  = 3'd1,
    PH_DRAIN = 3'd2,
    PH_RINSE = 3'd3,
    PH_FLUSH = 3'd4,
    PH_SPIN  = 3'd5
  } phase_e;

  localparam logic [PH_W-1:0] PH_LAST = 3'd5;

  // Table address layout, msb first.
  typedef struct packed {
    logic [PH_W-1:0] ph;
    logic            start;
    logic            off;
    logic            hot;
    logic            tdone;
    logic            full;
  } lut_addr_t;

  // Table word layout, msb first.
  typedef struct packed {
    logic [PH_W-1:0] nxt;
    logic            hot_v;
    logic            cold_v;
    logic            agit;
    logic            motor;
    logic            tstart;
  } lut_word_t;

  // Fill-or-agitate behaviour shared by wash and rinse.
  function automatic lut_word_t fill_step(input lut_word_t w_in, input logic full,
                                          input logic use_hot);
    lut_word_t w;
    w = w_in;
    if (full) begin
      w.agit = 1'b1;
    end else if (use_hot) begin
      w.hot_v = 1'b1;
    end else begin
      w.cold_v = 1'b1;
    end
    return w;
  endfunction

  // One table word, computed from its own address.
  function automatic lut_word_t lut_entry(input lut_addr_t a);
    lut_word_t w;
    w     = '0;
    w.nxt = a.ph;
    case (a.ph)
      PH_IDLE: begin
        if (a.start) begin
          w.nxt    = PH_WASH;
          w.tstart = 1'b1;
        end
      end
      PH_WASH: begin
        w = fill_step(w, a.full, a.hot);
        if (a.tdone && a.full) w.nxt = PH_DRAIN;
      end
      PH_DRAIN: begin
        w.motor = 1'b1;
        if (!a.full) begin
          w.nxt    = PH_RINSE;
          w.tstart = 1'b1;
        end
      end
      PH_RINSE: begin
        w = fill_step(w, a.full, 1'b0);
        if (a.tdone && a.full) w.nxt = PH_FLUSH;
      end
      PH_FLUSH: begin
        w.motor = 1'b1;
        if (!a.full) begin
          w.nxt    = PH_SPIN;
          w.tstart = 1'b1;
        end
      end
      PH_SPIN: begin
        w.motor = 1'b1;
        if (a.tdone) w.nxt = PH_IDLE;
      end
      default: w = '0;
    endcase
    if (a.off && (a.ph <= PH_LAST)) begin
      w     = '0;
      w.nxt = a.ph;
    end
    return w;
  endfunction

endpackage

// File: rtl/wm_seq_rom.sv
module wm_seq_rom
  import wm_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign tbl[g] = DW'(lut_entry(lut_addr_t'(AW'(g))));
  end

  assign data = tbl[addr];

endmodule

// File: rtl/wm_hold_ctl.sv
module wm_hold_ctl (
  input  logic clk,
  input  logic rst,
  input  logic off_btn,
  input  logic start_btn,
  output logic off_eff,
  output logic paused
);

  always_ff @(posedge clk) begin
    if (rst) begin
      paused <= 1'b0;
    end else if (off_btn) begin
      paused <= 1'b1;
    end else if (start_btn) begin
      paused <= 1'b0;
    end
  end

  // A start press releases a stored freeze in the same cycle.
  assign off_eff = off_btn | (paused & ~start_btn);

endmodule

// File: rtl/wm_act_decode.sv
module wm_act_decode
  import wm_pkg::*;
(
  input  logic [PH_W-1:0] phase,
  input  lut_word_t       word,
  output logic            hot_valve,
  output logic            cold_valve,
  output logic            agitator,
  output logic            drain_pump,
  output logic            spin_motor,
  output logic            stime_raw
);

  logic in_drain;
  logic in_spin;

  assign in_drain = (phase == PH_DRAIN) || (phase == PH_FLUSH);
  assign in_spin  = (phase == PH_SPIN);

  assign hot_valve  = word.hot_v;
  assign cold_valve = word.cold_v;
  assign agitator   = word.agit;
  assign drain_pump = word.motor & in_drain;
  assign spin_motor = word.motor & in_spin;
  assign stime_raw  = word.tstart;

endmodule

// File: rtl/wm_ctrl.sv
module wm_ctrl
  import wm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start_btn,
  input  logic            off_btn,
  input  logic            hot_sel,
  input  logic            timer_done,
  input  logic            tank_full,
  output logic            hot_valve,
  output logic            cold_valve,
  output logic            agitator,
  output logic            drain_pump,
  output logic            spin_motor,
  output logic            timer_start,
  output logic [PH_W-1:0] phase
);

  logic            off_eff;
  logic            paused;
  lut_addr_t       addr;
  logic [DATA_W-1:0] rom_data;
  lut_word_t       word;
  logic            stime_raw;
  logic [PH_W-1:0] phase_q;

  wm_hold_ctl u_hold (
    .clk       (clk),
    .rst       (rst),
    .off_btn   (off_btn),
    .start_btn (start_btn),
    .off_eff   (off_eff),
    .paused    (paused)
  );

  always_comb begin
    addr.ph    = phase_q;
    addr.start = start_btn;
    addr.off   = off_eff;
    addr.hot   = hot_sel;
    addr.tdone = timer_done;
    addr.full  = tank_full;
  end

  wm_seq_rom #(.AW(ADDR_W), .DW(DATA_W)) u_rom (
    .addr (addr),
    .data (rom_data)
  );

  assign word = lut_word_t'(rom_data);

  wm_act_decode u_dec (
    .phase      (phase_q),
    .word       (word),
    .hot_valve  (hot_valve),
    .cold_valve (cold_valve),
    .agitator   (agitator),
    .drain_pump (drain_pump),
    .spin_motor (spin_motor),
    .stime_raw  (stime_raw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      timer_start <= 1'b0;
    end else begin
      phase_q     <= word.nxt;
      timer_start <= stime_raw;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/wm_ctrl_chk.sv
module wm_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_btn,
  input logic       off_btn,
  input logic       tank_full,
  input logic [2:0] phase,
  input logic       hot_valve,
  input logic       cold_valve,
  input logic       agitator,
  input logic       drain_pump,
  input logic       spin_motor,
  input logic       timer_start,
  input logic       stime_raw,
  input logic       paused
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (phase == 3'd0 && !timer_start));

  a_r2_idle_needs_start: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd0 && !start_btn) |=> (phase == 3'd0));

  a_r3_fill_only_low: assert property (@(posedge clk) disable iff (rst)
    (hot_valve || cold_valve) |-> !tank_full);

  a_r6_tstart_delayed: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (timer_start == $past(stime_raw)));

  a_r6_tstart_single: assert property (@(posedge clk) disable iff (rst)
    timer_start |=> !timer_start);

  a_r7_off_freezes: assert property (@(posedge clk) disable iff (rst)
    off_btn |=> (phase == $past(phase)));

  a_r7_off_dark: assert property (@(posedge clk) disable iff (rst)
    off_btn |-> !(hot_valve || cold_valve || agitator || drain_pump || spin_motor));

  a_r7_pause_holds: assert property (@(posedge clk) disable iff (rst)
    (paused && !start_btn) |=> $stable(phase));

  a_r8_legal_code: assert property (@(posedge clk) disable iff (rst)
    phase <= 3'd5);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hot_valve | cold_valve, agitator, drain_pump, spin_motor})
    && !(hot_valve && cold_valve));

endmodule

bind wm_ctrl wm_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_btn   (start_btn),
  .off_btn     (off_btn),
  .tank_full   (tank_full),
  .phase       (phase),
  .hot_valve   (hot_valve),
  .cold_valve  (cold_valve),
  .agitator    (agitator),
  .drain_pump  (drain_pump),
  .spin_motor  (spin_motor),
  .timer_start (timer_start),
  .stime_raw   (stime_raw),
  .paused      (paused)
);

// File: tb/wm_ctrl_bench.sv
`timescale 1ns/1ps
module wm_ctrl_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_btn = 0, off_btn = 0, hot_sel = 0, timer_done = 0, tank_full = 0;
  logic hot_valve, cold_valve, agitator, drain_pump, spin_motor, timer_start;
  logic [2:0] phase;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wm_ctrl u_wm_ctrl (
    .clk(clk), .rst(rst), .start_btn(start_btn), .off_btn(off_btn),
    .hot_sel(hot_sel), .timer_done(timer_done), .tank_full(tank_full),
    .hot_valve(hot_valve), .cold_valve(cold_valve), .agitator(agitator),
    .drain_pump(drain_pump), .spin_motor(spin_motor),
    .timer_start(timer_start), .phase(phase)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected actuators packed as {hot, cold, agit, pump, spin}.
  function automatic int model_act(int ph, bit o, bit h, bit f);
    if (o) return 0;
    if (ph == 1 || ph == 3) begin
      if (f) return 5'b00100;
      return (ph == 1 && h) ? 5'b10000 : 5'b01000;
    end
    if (ph == 2 || ph == 4) return 5'b00010;
    if (ph == 5) return 5'b00001;
    return 0;
  endfunction

  function automatic int model_next(int ph, bit s, bit o, bit t, bit f);
    if (o) return ph;
    case (ph)
      0: return s ? 1 : 0;
      1: return (t && f) ? 2 : 1;
      2: return f ? 2 : 3;
      3: return (t && f) ? 4 : 3;
      4: return f ? 4 : 5;
      5: return t ? 0 : 5;
      default: return 0;
    endcase
  endfunction

  function automatic bit model_tstart(int ph, int nx);
    return (nx != ph) && (nx == 1 || nx == 3 || nx == 5);
  endfunction

  function automatic int act_vec();
    return {hot_valve, cold_valve, agitator, drain_pump, spin_motor};
  endfunction

  task automatic drive(input bit s, o, h, t, f);
    start_btn = s; off_btn = o; hot_sel = h; timer_done = t; tank_full = f;
  endtask

  task automatic step(input bit s, o, h, t, f);
    drive(s, o, h, t, f);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drive(0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic goto_phase(input int ph);
    do_reset();
    if (ph >= 1) step(1, 0, 0, 0, 0);
    if (ph >= 2) step(0, 0, 0, 1, 1);
    if (ph >= 3) step(0, 0, 0, 0, 0);
    if (ph >= 4) step(0, 0, 0, 1, 1);
    if (ph >= 5) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    check("R1", "phase after reset", phase, 0);
    check("R1", "timer_start after reset", timer_start, 0);
    check("R2", "idle actuators", act_vec(), 0);

    // Sweep every phase against every input combination.
    for (int ph = 0; ph < 6; ph++) begin
      for (int v = 0; v < 32; v++) begin
        bit s, o, h, t, f;
        int nx;
        {s, o, h, t, f} = v[4:0];
        goto_phase(ph);
        check("R4", "reached phase", phase, ph);
        drive(s, o, h, t, f);
        #2;
        check(o ? "R7" : "R3 R5 R9", "actuators", act_vec(), model_act(ph, o, h, f));
        nx = model_next(ph, s, o, t, f);
        @(negedge clk);
        check(o ? "R7" : (ph == 0 ? "R2" : "R4"), "next phase", phase, nx);
        check("R6", "timer_start", timer_start, model_tstart(ph, nx));
        check("R8", "phase code range", (phase <= 3'd5), 1);
      end
    end

    // R7: freeze persists after off is released, until start.
    goto_phase(1);
    check("R6", "strobe on wash entry", timer_start, 1);
    step(0, 1, 0, 1, 1);
    check("R7", "held under off", phase, 1);
    drive(0, 0, 0, 1, 1);
    #2;
    check("R7", "dark while paused", act_vec(), 0);
    @(negedge clk);
    check("R7", "paused ignores done", phase, 1);
    check("R7", "no strobe while paused", timer_start, 0);
    drive(1, 0, 0, 1, 1);
    #2;
    check("R7", "resume cycle agitates", agitator, 1);
    @(negedge clk);
    check("R7", "resume cycle advances", phase, 2);

    // R7: pause in idle then resume with start.
    do_reset();
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check("R7", "idle paused", phase, 0);
    step(1, 0, 0, 0, 0);
    check("R7", "idle resume to wash", phase, 1);

    // R1: reset mid-programme clears phase and strobe.
    goto_phase(3);
    check("R6", "strobe on rinse entry", timer_start, 1);
    rst = 1'b1;
    drive(1, 0, 1, 1, 1);
    @(negedge clk);
    check("R1", "phase under reset", phase, 0);
    check("R1", "strobe under reset", timer_start, 0);
    rst = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule